// File: doc/BRIEF.md
# Watchdog and Reset Status Controller

This block produces the chip-wide reset and records why the last restart happened. It takes four reset sources: the analog power-good detector, an active-low external reset pin, a free-running watchdog, and a resume wake that ends suspend mode. Every request is turned into one internal reset. That reset is stretched to a fixed length and released on a clock edge.

Firmware reaches the block through a small register write/read bus. The watchdog always runs while the chip is out of reset, and software cannot switch it off. The only way to restart it is to write the byte 55h to its clear offset. A status register holds two flags: a power-off flag and a suspend flag. After reset, firmware reads them to tell a cold start from a watchdog restart or a resume restart. Writing a two-byte key sequence to two neighbouring offsets puts the chip into suspend, which raises the stop-oscillator output until a wake event arrives.

Top module: `reset_supervisor`

## Requirements
- R1: While powerGood is low, chipRstN is low, stopOsc is low and the status register reads 02h. chipRstN rises exactly PorCycles + StretchCycles clock edges after powerGood rises.
- R2: Once chipRstN is high and no clear write arrives, the watchdog pulls chipRstN low exactly WdtPeriod clock edges after it rose. The watchdog cannot be disabled.
- R3: Writing 55h to offset 0Eh restarts the watchdog. The timeout then falls WdtPeriod edges after the edge that captured that write. Any other value written to 0Eh has no effect on the timeout.
- R4: After the last active reset request, chipRstN stays low for exactly StretchCycles (16) edges and then rises on a clock edge.
- R5: If extRstN is held low for ExtMinCycles (10) or more consecutive clocks, chipRstN falls 13 edges after the pin went low and rises 19 edges after the pin returns high. A low pulse of 9 clocks causes no reset.
- R6: The status register is at offset 0Fh, with the power-off flag in bit 1 and the suspend flag in bit 0; the other bits read 0. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged.
- R7: Power-up and an external reset set the power-off flag and clear the suspend flag. A watchdog reset clears the suspend flag and leaves the power-off flag unchanged. A resume reset sets the suspend flag and leaves the power-off flag unchanged.
- R8: A write of 55h to offset 1Eh arms the key. If the very next write is AAh to offset 1Fh, stopOsc rises. A wrong value, a wrong order or any other write in between leaves stopOsc low.
- R9: While suspended, the watchdog is frozen and bus writes are ignored. A resumeWake pulse starts a reset on the next edge, drops stopOsc and sets the suspend flag.
- R10: busRdData returns the status byte only when busAddr is 0Fh. It reads 00h at every other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| powerGood | input | 1 | Supply-valid level from the analog detector; low resets the whole block asynchronously |
| extRstN | input | 1 | External reset pin, active low, asynchronous to clk |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 5 | Register offset for writes and reads |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| resumeWake | input | 1 | Wake event that ends suspend |
| chipRstN | output | 1 | Chip reset, active low, released synchronously |
| stopOsc | output | 1 | High while the chip is suspended |

## Verification
The timeout is tried three ways, and each tells a different fault apart. With no clear write at all, the test shows whether the watchdog period is right. With a 55h clear in the middle of the period, it shows that the restart really restarts the count. With 54h and AAh written to the clear offset, it shows that only the exact byte counts. External pulses of 9 and 25 clocks separate the length filter from a plain level reset. They also show that the release tracks the end of the pin's low level. The key sequence is tried correct, with an intervening write, with wrong values and with the order reversed. The status byte is read after each kind of restart, which separates cold, watchdog and resume starts.

// File: rtl/wdrst_pkg.sv
package wdrst_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_WDT_CLEAR = 5'h0E;
  localparam logic [ADDR_W-1:0] OFS_STATUS    = 5'h0F;
  localparam logic [ADDR_W-1:0] OFS_KEY_FIRST = 5'h1E;
  localparam logic [ADDR_W-1:0] OFS_KEY_LAST  = 5'h1F;

  localparam logic [DATA_W-1:0] VAL_WDT_CLEAR = 8'h55;
  localparam logic [DATA_W-1:0] VAL_KEY_FIRST = 8'h55;
  localparam logic [DATA_W-1:0] VAL_KEY_LAST  = 8'hAA;

  localparam int BIT_POWER_OFF = 1;
  localparam int BIT_SUSPENDED = 0;

  typedef struct packed {
    logic wdtKick;
    logic wdtHold;
    logic resumeReq;
  } dpStrobe_t;

endpackage

// File: rtl/wdrst_datapath.sv
module wdrst_datapath
  import wdrst_pkg::*;
#(
  parameter int PorCycles     = 30000,
  parameter int WdtPeriod     = 900000,
  parameter int ExtMinCycles  = 10,
  parameter int StretchCycles = 16
) (
  input  logic      clk,
  input  logic      powerGood,
  input  logic      extPinN,
  input  dpStrobe_t strobe,
  output logic      porBusy,
  output logic      extHit,
  output logic      wdtFire,
  output logic      chipRstN
);

  localparam int PorW = $clog2(PorCycles + 1);
  localparam int WdtW = $clog2(WdtPeriod);
  localparam int ExtW = $clog2(ExtMinCycles + 1);
  localparam int StrW = $clog2(StretchCycles + 1);
  localparam logic [PorW-1:0] PorInit  = PorW'(PorCycles);
  localparam logic [WdtW-1:0] WdtLast  = WdtW'(WdtPeriod - 1);
  localparam logic [ExtW-1:0] ExtLimit = ExtW'(ExtMinCycles);
  localparam logic [StrW-1:0] StrLoad  = StrW'(StretchCycles);

  logic [PorW-1:0] porCnt;
  logic [1:0]      extSync;
  logic [ExtW-1:0] lowCnt;
  logic [WdtW-1:0] wdtCnt;
  logic [StrW-1:0] strCnt;
  logic [StrW-1:0] strNext;
  logic            rstNq;
  logic            rstReq;

  // power-on pulse counter
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)          porCnt <= PorInit;
    else if (porCnt != '0)   porCnt <= porCnt - 1'b1;
  end
  assign porBusy = (porCnt != '0);

  // external pin: two-flop synchronizer then a run-length filter
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) extSync <= 2'b11;
    else            extSync <= {extSync[0], extPinN};
  end

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)              lowCnt <= '0;
    else if (extSync[1])         lowCnt <= '0;
    else if (lowCnt != ExtLimit) lowCnt <= lowCnt + 1'b1;
  end
  assign extHit = (lowCnt == ExtLimit);

  // watchdog: runs whenever the chip is out of reset, frozen only in suspend
  assign wdtFire = rstNq && !strobe.wdtHold && !strobe.wdtKick && (wdtCnt == WdtLast);

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)                               wdtCnt <= '0;
    else if (!rstNq || strobe.wdtKick || wdtFire) wdtCnt <= '0;
    else if (!strobe.wdtHold)                     wdtCnt <= wdtCnt + 1'b1;
  end

  // reset stretcher with synchronous release
  assign rstReq = porBusy || extHit || wdtFire || strobe.resumeReq;

  always_comb begin
    if (rstReq)              strNext = StrLoad;
    else if (strCnt != '0)   strNext = strCnt - 1'b1;
    else                     strNext = '0;
  end

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      strCnt <= StrLoad;
      rstNq  <= 1'b0;
    end else begin
      strCnt <= strNext;
      rstNq  <= (strNext == '0);
    end
  end
  assign chipRstN = rstNq;

  assert_wdt_bound_R2: assert property (@(posedge clk) disable iff (!powerGood)
    wdtCnt <= WdtLast);

  assert_req_holds_R4: assert property (@(posedge clk) disable iff (!powerGood)
    rstReq |=> !chipRstN);

  assert_release_quiet_R4: assert property (@(posedge clk) disable iff (!powerGood)
    $rose(chipRstN) |-> $past(!rstReq));

  assert_por_low_R1: assert property (@(posedge clk) disable iff (!powerGood)
    porBusy |-> !chipRstN);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!powerGood)
    (strobe.wdtHold && rstNq) |=> $stable(wdtCnt));

endmodule

// File: rtl/wdrst_ctrl.sv
module wdrst_ctrl
  import wdrst_pkg::*;
(
  input  logic              clk,
  input  logic              powerGood,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              resumeWake,
  input  logic              porBusy,
  input  logic              extHit,
  input  logic              wdtFire,
  input  logic              chipRstN,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] busRdData,
  output logic              stopOsc
);

  logic powerOff;
  logic suspFlag;
  logic keyArmed;
  logic suspended;
  logic wrOk;
  logic keyEnter;
  logic statusWr;

  assign wrOk     = busWrEn && chipRstN && !suspended;
  assign statusWr = wrOk && (busAddr == OFS_STATUS);
  assign keyEnter = wrOk && keyArmed && (busAddr == OFS_KEY_LAST) && (busWrData == VAL_KEY_LAST);

  always_comb begin
    strobe           = '0;
    strobe.wdtKick   = wrOk && (busAddr == OFS_WDT_CLEAR) && (busWrData == VAL_WDT_CLEAR);
    strobe.wdtHold   = suspended;
    strobe.resumeReq = suspended && resumeWake;
  end

  // key sequence and suspend state
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      keyArmed  <= 1'b0;
      suspended <= 1'b0;
    end else begin
      if (!chipRstN)  keyArmed <= 1'b0;
      else if (wrOk)  keyArmed <= (busAddr == OFS_KEY_FIRST) && (busWrData == VAL_KEY_FIRST);

      if (strobe.resumeReq || extHit || porBusy) suspended <= 1'b0;
      else if (keyEnter)                         suspended <= 1'b1;
    end
  end
  assign stopOsc = suspended;

  // restart-cause flags
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      powerOff <= 1'b1;
      suspFlag <= 1'b0;
    end else if (extHit) begin
      powerOff <= 1'b1;
      suspFlag <= 1'b0;
    end else if (wdtFire) begin
      suspFlag <= 1'b0;
    end else if (strobe.resumeReq) begin
      suspFlag <= 1'b1;
    end else if (statusWr) begin
      powerOff <= powerOff & busWrData[BIT_POWER_OFF];
      suspFlag <= suspFlag & busWrData[BIT_SUSPENDED];
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == OFS_STATUS) begin
      busRdData[BIT_POWER_OFF] = powerOff;
      busRdData[BIT_SUSPENDED] = suspFlag;
    end
  end

  assert_enter_key_R8: assert property (@(posedge clk) disable iff (!powerGood)
    $rose(stopOsc) |-> $past(busWrEn && busAddr == OFS_KEY_LAST && busWrData == VAL_KEY_LAST));

  assert_pof_hw_only_R6: assert property (@(posedge clk) disable iff (!powerGood)
    $rose(powerOff) |-> !chipRstN);

  assert_susf_on_resume_R7: assert property (@(posedge clk) disable iff (!powerGood)
    $rose(suspFlag) |-> !chipRstN);

  assert_no_write_in_susp_R9: assert property (@(posedge clk) disable iff (!powerGood)
    (suspended && !resumeWake && !extHit) |=> suspended);

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import wdrst_pkg::*;
#(
  parameter int PorCycles     = 30000,
  parameter int WdtPeriod     = 900000,
  parameter int ExtMinCycles  = 10,
  parameter int StretchCycles = 16
) (
  input  logic       clk,
  input  logic       powerGood,
  input  logic       extRstN,
  input  logic       busWrEn,
  input  logic [4:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       resumeWake,
  output logic       chipRstN,
  output logic       stopOsc
);

  dpStrobe_t strobe;
  logic      porBusy;
  logic      extHit;
  logic      wdtFire;

  wdrst_ctrl u_ctrl (
    .clk        (clk),
    .powerGood  (powerGood),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .resumeWake (resumeWake),
    .porBusy    (porBusy),
    .extHit     (extHit),
    .wdtFire    (wdtFire),
    .chipRstN   (chipRstN),
    .strobe     (strobe),
    .busRdData  (busRdData),
    .stopOsc    (stopOsc)
  );

  wdrst_datapath #(
    .PorCycles     (PorCycles),
    .WdtPeriod     (WdtPeriod),
    .ExtMinCycles  (ExtMinCycles),
    .StretchCycles (StretchCycles)
  ) u_dp (
    .clk       (clk),
    .powerGood (powerGood),
    .extPinN   (extRstN),
    .strobe    (strobe),
    .porBusy   (porBusy),
    .extHit    (extHit),
    .wdtFire   (wdtFire),
    .chipRstN  (chipRstN)
  );

endmodule

// File: tb/tb_reset_supervisor.sv
`timescale 1ns/1ps
module tb_reset_supervisor;

  localparam int P = 40;
  localparam int W = 200;
  localparam int S = 16;

  logic       clk = 1'b0;
  logic       powerGood = 1'b0;
  logic       extRstN = 1'b1;
  logic       busWrEn = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       resumeWake = 1'b0;
  logic       chipRstN;
  logic       stopOsc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    bit    lvl;
    int    at;
    string tag;
  } evt_t;
  evt_t expQ[$];
  bit   prevLvl = 1'b0;

  reset_supervisor #(.PorCycles(P), .WdtPeriod(W), .ExtMinCycles(10), .StretchCycles(S)) dut (
    .clk(clk), .powerGood(powerGood), .extRstN(extRstN), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .resumeWake(resumeWake), .chipRstN(chipRstN), .stopOsc(stopOsc)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic pushEdge(input bit lvl, input int at, input string tag);
    evt_t e;
    e.lvl = lvl; e.at = at; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compares every chipRstN transition with the scoreboard queue
  always @(negedge clk) begin
    if (chipRstN !== prevLvl) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected chipRstN edge: actual %0b at cycle %0d expected none", chipRstN, cyc);
      end else begin
        evt_t e;
        e = expQ.pop_front();
        if (e.lvl !== chipRstN || e.at != cyc) begin
          errors++;
          $display("FAIL %s: actual level %0b at cycle %0d expected level %0b at cycle %0d",
                   e.tag, chipRstN, cyc, e.lvl, e.at);
        end
      end
      prevLvl = chipRstN;
    end
  end

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    busAddr = a;
    #1;
    check(busRdData === exp, tag, busRdData, exp);
    busAddr = '0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int e1, r1, k, r2, c;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(chipRstN === 1'b0, "R1 chipRstN in power-down", chipRstN, 0);
    check(stopOsc === 1'b0, "R1 stopOsc in power-down", stopOsc, 0);
    rd(5'h0F, 8'h02, "R1 status after power-up");
    rd(5'h0E, 8'h00, "R10 read of clear offset");
    rd(5'h1E, 8'h00, "R10 read of key offset");

    // R1 power-on timing, then R2 free-running timeout and R4 stretch
    e1 = cyc + P + S;
    pushEdge(1'b1, e1, "R1 power-on release");
    pushEdge(1'b0, e1 + W, "R2 watchdog timeout");
    pushEdge(1'b1, e1 + W + S, "R4 stretch after watchdog");
    powerGood = 1'b1;
    waitUntil(e1);
    wr(5'h0F, 8'h00);
    rd(5'h0F, 8'h00, "R6 power-off flag cleared by writing 0");
    waitUntil(e1 + W + S + 1);
    rd(5'h0F, 8'h00, "R7 watchdog restart keeps flags at 0");

    // R3 clear write restarts; other values ignored
    r1 = e1 + W + S;
    waitUntil(r1 + 50);
    k = cyc + 1;
    wr(5'h0E, 8'h55);
    pushEdge(1'b0, k + W, "R3 timeout after clear");
    pushEdge(1'b1, k + W + S, "R4 stretch after cleared timeout");
    waitUntil(k + 100);
    wr(5'h0E, 8'h54);
    wr(5'h0E, 8'hAA);
    waitUntil(k + W + S + 1);
    r2 = k + W + S;
    rd(5'h0F, 8'h00, "R7 flags after second watchdog restart");

    // R8 correct key sequence enters suspend, R9 watchdog frozen
    wr(5'h1E, 8'h55);
    wr(5'h1F, 8'hAA);
    check(stopOsc === 1'b1, "R8 stopOsc after key pair", stopOsc, 1);
    wr(5'h0E, 8'h55);
    wr(5'h0F, 8'h00);
    repeat (W + 50) @(negedge clk);
    check(chipRstN === 1'b1, "R9 no timeout while suspended", chipRstN, 1);
    check(stopOsc === 1'b1, "R9 still suspended before wake", stopOsc, 1);
    c = cyc + 1;
    pushEdge(1'b0, c, "R9 resume reset");
    pushEdge(1'b1, c + S, "R4 stretch after resume");
    resumeWake = 1'b1;
    @(negedge clk);
    resumeWake = 1'b0;
    check(stopOsc === 1'b0, "R9 stopOsc dropped on wake", stopOsc, 0);
    waitUntil(c + S + 1);
    rd(5'h0F, 8'h01, "R7 resume sets suspend flag only");
    wr(5'h0F, 8'hFF);
    rd(5'h0F, 8'h01, "R6 writing 1 does not set power-off flag");

    // R8 broken key sequences
    wr(5'h1E, 8'h55);
    wr(5'h0E, 8'h55);
    wr(5'h1F, 8'hAA);
    check(stopOsc === 1'b0, "R8 intervening write disarms", stopOsc, 0);
    wr(5'h1E, 8'h55);
    wr(5'h1F, 8'h55);
    check(stopOsc === 1'b0, "R8 wrong second value", stopOsc, 0);
    wr(5'h1F, 8'hAA);
    check(stopOsc === 1'b0, "R8 second key alone", stopOsc, 0);
    wr(5'h1F, 8'hAA);
    wr(5'h1E, 8'h55);
    check(stopOsc === 1'b0, "R8 reversed order", stopOsc, 0);
    wr(5'h1E, 8'hAA);
    wr(5'h1F, 8'hAA);
    check(stopOsc === 1'b0, "R8 wrong first value", stopOsc, 0);

    // R5 short external pulse is filtered
    wr(5'h0E, 8'h55);
    extRstN = 1'b0;
    repeat (9) @(negedge clk);
    extRstN = 1'b1;
    repeat (20) @(negedge clk);
    check(chipRstN === 1'b1, "R5 nine-clock pulse ignored", chipRstN, 1);

    // R5 long external pulse, R7 cold flags
    wr(5'h0E, 8'h55);
    c = cyc;
    pushEdge(1'b0, c + 13, "R5 external reset assert");
    pushEdge(1'b1, c + 25 + 19, "R5 external reset release");
    extRstN = 1'b0;
    repeat (25) @(negedge clk);
    extRstN = 1'b1;
    waitUntil(c + 46);
    rd(5'h0F, 8'h02, "R7 external reset sets power-off, clears suspend");

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R4 all expected reset edges seen", expQ.size(), 0);
    summary();
  end

endmodule